// File: doc/BRIEF.md
# Function-Unit Operand and Result Handshake Controller

This block is the control core of a scoreboard-style computation unit. An instruction arrives with a 2-bit opcode on a valid/ready issue channel. The controller then asks for its two operands through a read-release vector that has one bit per read port. Each port is granted on its own by the matching go-read bit, which also captures that port's operand. When every operand is in, a fixed-latency arithmetic stub runs. Its result is then offered on a release/grant output channel. Write-release acts as valid and go-write acts as ready.

The result commit is held off while the active-low shadow input is low, which means a speculation is still unresolved. A kill input (go-die) aborts the operation in any phase, and it takes priority over every grant. After a write grant or a kill, the unit returns to idle and its busy output drops. Register-file storage, dependency tracking and real arithmetic are out of scope.

Back-pressure rules: an issue transfers on a clock edge where `issue_valid_i` and `issue_ready_o` are both high and `go_die_i` is low. `issue_ready_o` is high exactly when the unit is idle. A result transfers on an edge where `wr_rel_o`, `go_wr_i` and `shadow_n_i` are all high. `wr_data_o` is stable for as long as `wr_rel_o` is high.

Top module: `fu_handshake_ctl`

## Requirements
- R1: An issue is accepted only while the unit is idle and `go_die_i` is low. On the edge that accepts it, `busy_o` and every `rd_rel_o` bit go high. An issue while busy, or in the same cycle as `go_die_i`, is ignored, and the opcode already held is unchanged.
- R2: `rst_i` is a synchronous reset that clears every request and `busy_o`. No read-release or write-release bit is ever high unless an issue has been accepted since the last reset.
- R3: A high `rd_rel_o[i]` stays high until an edge that samples `go_rd_i[i]` high or `go_die_i` high.
- R4: An edge that samples `go_rd_i[i]` while `rd_rel_o[i]` is high clears that bit and leaves the other bits unchanged. The same edge captures operand i from `rd_data_i[i*DATA_W +: DATA_W]`. A go-read on a bit that is already low is ignored and does not recapture the operand.
- R5: An edge that samples `go_die_i` while any read-release bit is high clears all of them, returns the unit to idle, and no write-release follows.
- R6: Suppose the last outstanding read grant is sampled at edge n. Then `wr_rel_o` goes high at edge n+ALU_LAT, with `wr_data_o` = f(op, A, B). A is operand 0 and B is operand 1, and the result is computed modulo 2^DATA_W. The opcodes are: 0 = A+B, 1 = A-B, 2 = A AND B, 3 = A XOR B.
- R7: An edge with `wr_rel_o`, `go_wr_i` and `shadow_n_i` all high clears `wr_rel_o`.
- R8: An edge with `wr_rel_o` and `go_die_i` both high clears `wr_rel_o`, whatever the state of the shadow input.
- R9: While `shadow_n_i` is low, `wr_rel_o` does not fall unless `go_die_i` is high, even if `go_wr_i` is high.
- R10: A `go_wr_i` that arrives without a pending write-release is ignored: the unit stays idle if it was idle, and stays busy if it was busy.
- R11: `busy_o` drops on the edge that retires or kills the operation, and `issue_ready_o` equals the inverse of `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| issue_valid_i | input | 1 | Issue request valid |
| issue_ready_o | output | 1 | Unit idle, issue can be taken |
| issue_op_i | input | 2 | Opcode for the stub ALU |
| go_die_i | input | 1 | Kill the current operation |
| rd_rel_o | output | NUM_RD | Per-port operand request |
| go_rd_i | input | NUM_RD | Per-port read grant |
| rd_data_i | input | NUM_RD*DATA_W | Operand data, port i in slice i |
| wr_rel_o | output | 1 | Result request (valid) |
| go_wr_i | input | 1 | Result grant (ready) |
| shadow_n_i | input | 1 | Low while speculation is unresolved |
| wr_data_o | output | DATA_W | Result value |
| busy_o | output | 1 | An operation is in flight |

## Verification
The properties take for granted that `rst_i` is high from time zero until the first edges. They also rely on the unit's own idle gating: a new load can never coincide with outstanding requests, so they do not constrain an issue that arrives while busy. The stimulus deliberately drives stray issues, go-read on bits that are already cleared, and go-write while no result is pending. It sweeps every opcode, every grant order and several shadow hold lengths, and it changes inputs only at the falling clock edge.

// File: rtl/fuh_pkg.sv
package fuh_pkg;
  localparam int FUH_OP_W = 2;

  typedef enum logic [FUH_OP_W-1:0] {
    FUH_ADD = 2'd0,
    FUH_SUB = 2'd1,
    FUH_AND = 2'd2,
    FUH_XOR = 2'd3
  } fuh_op_e;
endpackage

// File: rtl/fuh_read_ports.sv
module fuh_read_ports #(
  parameter int NUM_RD = 2,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     load_i,
  input  logic                     kill_i,
  input  logic [NUM_RD-1:0]        go_rd_i,
  input  logic [NUM_RD*DATA_W-1:0] rd_data_i,
  output logic [NUM_RD-1:0]        rd_rel_o,
  output logic [NUM_RD*DATA_W-1:0] opnd_o,
  output logic                     last_o
);
  localparam int TOT_W = NUM_RD * DATA_W;

  logic [NUM_RD-1:0] grant;
  logic [NUM_RD-1:0] remain;

  assign grant  = rd_rel_o & go_rd_i & {NUM_RD{~kill_i}};
  assign remain = rd_rel_o & ~go_rd_i;
  assign last_o = (|rd_rel_o) & (remain == '0) & ~kill_i;

  for (genvar i = 0; i < NUM_RD; i++) begin : g_port
    logic              rel_r;
    logic [DATA_W-1:0] opnd_r;

    always_ff @(posedge clk_i) begin
      if (rst_i)       rel_r <= 1'b0;
      else if (kill_i) rel_r <= 1'b0;
      else if (load_i) rel_r <= 1'b1;
      else if (grant[i]) rel_r <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (rst_i)         opnd_r <= '0;
      else if (grant[i]) opnd_r <= rd_data_i[i*DATA_W +: DATA_W];
    end

    assign rd_rel_o[i]              = rel_r;
    assign opnd_o[i*DATA_W +: DATA_W] = opnd_r;

    // R3: request held until its own grant or a kill
    p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_rel_o[i] && !go_rd_i[i] && !kill_i |=> rd_rel_o[i])
      else $error("p_rd_hold_r3 port %0d", i);

    // R4: granted bit clears on the next cycle
    p_rd_grant_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_rel_o[i] && go_rd_i[i] |=> !rd_rel_o[i])
      else $error("p_rd_grant_r4 port %0d", i);

    // R4: operand unchanged unless this port is granted
    p_opnd_keep_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      !(rd_rel_o[i] && go_rd_i[i]) |=> $stable(opnd_o[i*DATA_W +: DATA_W]))
      else $error("p_opnd_keep_r4 port %0d", i);
  end

  // R5: kill wipes every read request
  p_rd_kill_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (|rd_rel_o) && kill_i |=> rd_rel_o == '0)
    else $error("p_rd_kill_r5");

  logic unused_w;
  assign unused_w = ^TOT_W;
endmodule

// File: rtl/fuh_alu_stub.sv
module fuh_alu_stub
  import fuh_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ALU_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              kill_i,
  input  fuh_op_e           op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  logic [ALU_LAT-1:0] pipe_q;

  if (ALU_LAT == 1) begin : g_single
    always_ff @(posedge clk_i) begin
      if (rst_i || kill_i) pipe_q <= '0;
      else                 pipe_q <= start_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i) begin
      if (rst_i || kill_i) pipe_q <= '0;
      else                 pipe_q <= {pipe_q[ALU_LAT-2:0], start_i};
    end
  end

  assign busy_o = |pipe_q;
  assign done_o = pipe_q[ALU_LAT-1];

  always_comb begin
    unique case (op_i)
      FUH_ADD: result_o = opa_i + opb_i;
      FUH_SUB: result_o = opa_i - opb_i;
      FUH_AND: result_o = opa_i & opb_i;
      FUH_XOR: result_o = opa_i ^ opb_i;
      default: result_o = opa_i;
    endcase
  end

  // R6: only one operation is ever in flight in the stub
  p_alu_single_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(pipe_q))
    else $error("p_alu_single_r6");
endmodule

// File: rtl/fuh_write_rel.sv
module fuh_write_rel #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              go_wr_i,
  input  logic              shadow_n_i,
  input  logic              kill_i,
  output logic              wr_rel_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic commit;
  assign commit = wr_rel_o & go_wr_i & shadow_n_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)       wr_rel_o <= 1'b0;
    else if (kill_i) wr_rel_o <= 1'b0;
    else if (set_i)  wr_rel_o <= 1'b1;
    else if (commit) wr_rel_o <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)      wr_data_o <= '0;
    else if (set_i) wr_data_o <= result_i;
  end

  // R7: a granted, unshadowed result retires
  p_wr_grant_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_rel_o && go_wr_i && shadow_n_i |=> !wr_rel_o)
    else $error("p_wr_grant_r7");

  // R8: kill drops the result request
  p_wr_kill_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_rel_o && kill_i |=> !wr_rel_o)
    else $error("p_wr_kill_r8");

  // R9: pending shadow holds the request
  p_wr_shadow_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_rel_o && !shadow_n_i && !kill_i |=> wr_rel_o)
    else $error("p_wr_shadow_r9");

  // R6: result is stable while offered
  p_wr_data_stable_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_rel_o && !kill_i && !commit |=> $stable(wr_data_o))
    else $error("p_wr_data_stable_r6");
endmodule

// File: rtl/fu_handshake_ctl.sv
module fu_handshake_ctl
  import fuh_pkg::*;
#(
  parameter int NUM_RD  = 2,
  parameter int DATA_W  = 8,
  parameter int ALU_LAT = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     issue_valid_i,
  output logic                     issue_ready_o,
  input  logic [FUH_OP_W-1:0]      issue_op_i,
  input  logic                     go_die_i,
  output logic [NUM_RD-1:0]        rd_rel_o,
  input  logic [NUM_RD-1:0]        go_rd_i,
  input  logic [NUM_RD*DATA_W-1:0] rd_data_i,
  output logic                     wr_rel_o,
  input  logic                     go_wr_i,
  input  logic                     shadow_n_i,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic                     busy_o
);
  logic                     accept;
  logic                     rd_last;
  logic                     alu_busy;
  logic                     alu_done;
  logic [DATA_W-1:0]        alu_res;
  logic [NUM_RD*DATA_W-1:0] opnd;
  fuh_op_e                  op_q;
  logic                     issued_q;

  assign busy_o        = (|rd_rel_o) | alu_busy | wr_rel_o;
  assign issue_ready_o = ~busy_o;
  assign accept        = issue_valid_i & ~busy_o & ~go_die_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)       op_q <= FUH_ADD;
    else if (accept) op_q <= fuh_op_e'(issue_op_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       issued_q <= 1'b0;
    else if (accept) issued_q <= 1'b1;
  end

  fuh_read_ports #(.NUM_RD(NUM_RD), .DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (accept),
    .kill_i    (go_die_i),
    .go_rd_i   (go_rd_i),
    .rd_data_i (rd_data_i),
    .rd_rel_o  (rd_rel_o),
    .opnd_o    (opnd),
    .last_o    (rd_last)
  );

  fuh_alu_stub #(.DATA_W(DATA_W), .ALU_LAT(ALU_LAT)) u_alu (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (rd_last),
    .kill_i   (go_die_i),
    .op_i     (op_q),
    .opa_i    (opnd[0 +: DATA_W]),
    .opb_i    (opnd[DATA_W +: DATA_W]),
    .busy_o   (alu_busy),
    .done_o   (alu_done),
    .result_o (alu_res)
  );

  fuh_write_rel #(.DATA_W(DATA_W)) u_wr (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .set_i      (alu_done & ~go_die_i),
    .result_i   (alu_res),
    .go_wr_i    (go_wr_i),
    .shadow_n_i (shadow_n_i),
    .kill_i     (go_die_i),
    .wr_rel_o   (wr_rel_o),
    .wr_data_o  (wr_data_o)
  );

  // R1: accepted issue raises busy and every read request
  p_issue_load_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    issue_valid_i && issue_ready_o && !go_die_i |=> busy_o && (&rd_rel_o))
    else $error("p_issue_load_r1");

  // R1: issue while busy keeps the held opcode
  p_issue_busy_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |=> $stable(op_q))
    else $error("p_issue_busy_r1");

  // R2: no request without a prior accepted issue
  p_rel_after_issue_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (|rd_rel_o) || wr_rel_o |-> issued_q)
    else $error("p_rel_after_issue_r2");

  // R6: a finished, unkilled operation offers its result
  p_result_raise_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    alu_done && !go_die_i |=> wr_rel_o)
    else $error("p_result_raise_r6");

  // R10: stray go-write leaves a busy unit busy
  p_stray_wr_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    go_wr_i && !wr_rel_o && busy_o && !go_die_i |=> busy_o)
    else $error("p_stray_wr_r10");

  // R11: retire or kill returns the unit to idle
  p_idle_after_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_rel_o && (go_die_i || (go_wr_i && shadow_n_i)) |=> !busy_o)
    else $error("p_idle_after_r11");
endmodule

// File: tb/fu_handshake_ctl_bench.sv
module fu_handshake_ctl_bench;
  localparam int NRD = 2;
  localparam int DW  = 8;
  localparam int LAT = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic            issue_valid;
  logic            issue_ready;
  logic [1:0]      issue_op;
  logic            go_die;
  logic [NRD-1:0]  rd_rel;
  logic [NRD-1:0]  go_rd;
  logic [NRD*DW-1:0] rd_data;
  logic            wr_rel;
  logic            go_wr;
  logic            shadow_n;
  logic [DW-1:0]   wr_data;
  logic            busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fu_handshake_ctl #(.NUM_RD(NRD), .DATA_W(DW), .ALU_LAT(LAT)) u_fu_handshake_ctl (
    .clk_i(clk), .rst_i(rst), .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .issue_op_i(issue_op), .go_die_i(go_die), .rd_rel_o(rd_rel), .go_rd_i(go_rd),
    .rd_data_i(rd_data), .wr_rel_o(wr_rel), .go_wr_i(go_wr), .shadow_n_i(shadow_n),
    .wr_data_o(wr_data), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int exp_res(input int op, input int a, input int b);
    case (op)
      0: return (a + b) & 255;
      1: return (a - b) & 255;
      2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic idle_inputs();
    issue_valid = 0; go_die = 0; go_rd = 0; go_wr = 0; shadow_n = 1; rd_data = '0;
  endtask

  // issue then grant both ports in the given order; ends at the negedge after last grant
  task automatic issue_and_read(input int op, input int a, input int b, input int order);
    issue_valid = 1; issue_op = 2'(op);
    chk("R11 ready when idle", int'(issue_ready), 1);
    cyc(); issue_valid = 0;
    chk("R1 busy after issue", int'(busy), 1);
    chk("R1 both requests", int'(rd_rel), 3);
    chk("R2 no write yet", int'(wr_rel), 0);
    // stray issue with other opcode and stray go-write while reading
    issue_valid = 1; issue_op = 2'(op ^ 1); go_wr = 1;
    cyc(); issue_valid = 0; go_wr = 0;
    chk("R3 requests held", int'(rd_rel), 3);
    chk("R10 stray go-write keeps busy", int'(busy), 1);
    case (order)
      0: begin
        go_rd = 2'b11; rd_data = {8'(b), 8'(a)};
        cyc(); go_rd = 0;
      end
      1: begin
        go_rd = 2'b01; rd_data = {8'h5A, 8'(a)};
        cyc();
        chk("R4 port0 cleared only", int'(rd_rel), 2);
        go_rd = 2'b11; rd_data = {8'(b), ~8'(a)};
        cyc(); go_rd = 0;
      end
      default: begin
        go_rd = 2'b10; rd_data = {8'(b), 8'hA5};
        cyc();
        chk("R4 port1 cleared only", int'(rd_rel), 1);
        go_rd = 2'b11; rd_data = {~8'(b), 8'(a)};
        cyc(); go_rd = 0;
      end
    endcase
    chk("R4 all granted", int'(rd_rel), 0);
  endtask

  task automatic wait_result(input int op, input int a, input int b);
    chk("R6 not early", int'(wr_rel), 0);
    for (int j = 0; j < LAT - 1; j++) begin
      cyc();
      chk("R6 not early", int'(wr_rel), 0);
    end
    cyc();
    chk("R6 raised on time", int'(wr_rel), 1);
    chk("R6 result value", int'(wr_data), exp_res(op, a, b));
  endtask

  task automatic run_op(input int op, input int a, input int b, input int order, input int sh);
    issue_and_read(op, a, b, order);
    wait_result(op, a, b);
    for (int s = 0; s < sh; s++) begin
      shadow_n = 0; go_wr = 1;
      cyc();
      chk("R9 held under shadow", int'(wr_rel), 1);
    end
    shadow_n = 1; go_wr = 1;
    cyc(); go_wr = 0;
    chk("R7 retired", int'(wr_rel), 0);
    chk("R11 idle after retire", int'(busy), 0);
    chk("R11 ready after retire", int'(issue_ready), 1);
  endtask

  initial begin
    rst = 1; issue_op = 0;
    idle_inputs();
    repeat (3) cyc();
    chk("R2 reset rd_rel", int'(rd_rel), 0);
    chk("R2 reset wr_rel", int'(wr_rel), 0);
    chk("R2 reset busy", int'(busy), 0);
    rst = 0;
    cyc();
    // R10: go-write while idle
    go_wr = 1; cyc(); go_wr = 0;
    chk("R10 idle stays idle", int'(busy), 0);
    chk("R10 no write", int'(wr_rel), 0);
    // R1: issue together with kill is ignored
    issue_valid = 1; go_die = 1; cyc(); issue_valid = 0; go_die = 0;
    chk("R1 issue with kill ignored", int'(busy), 0);

    for (int op = 0; op < 4; op++)
      for (int order = 0; order < 3; order++)
        for (int sh = 0; sh < 3; sh++)
          run_op(op, (op * 37 + order * 11 + 5) & 255, (sh * 73 + 200 - op) & 255, order, sh);

    // R5: kill after a partial grant
    issue_valid = 1; issue_op = 0; cyc(); issue_valid = 0;
    go_rd = 2'b01; cyc(); go_rd = 0;
    chk("R4 partial", int'(rd_rel), 2);
    go_die = 1; cyc(); go_die = 0;
    chk("R5 requests wiped", int'(rd_rel), 0);
    chk("R5 idle", int'(busy), 0);
    for (int j = 0; j < LAT + 2; j++) begin
      cyc();
      chk("R5 no result follows", int'(wr_rel), 0);
    end

    // kill during execution
    issue_and_read(2, 8'hF0, 8'h3C, 0);
    go_die = 1; cyc(); go_die = 0;
    chk("R5 kill in execution idles", int'(busy), 0);
    for (int j = 0; j < LAT + 1; j++) begin
      cyc();
      chk("R5 no result after kill", int'(wr_rel), 0);
    end

    // R8: kill during write overrides pending shadow
    issue_and_read(1, 10, 20, 1);
    wait_result(1, 10, 20);
    shadow_n = 0; go_die = 1; cyc(); go_die = 0; shadow_n = 1;
    chk("R8 kill drops write", int'(wr_rel), 0);
    chk("R8 idle after kill", int'(busy), 0);

    // R2: mid-operation reset
    issue_and_read(3, 1, 2, 0);
    rst = 1; cyc(); rst = 0;
    chk("R2 reset clears busy", int'(busy), 0);
    chk("R2 reset clears requests", int'(rd_rel), 0);
    for (int j = 0; j < LAT + 1; j++) begin
      cyc();
      chk("R2 no write after reset", int'(wr_rel), 0);
    end

    // recovery
    run_op(0, 255, 1, 2, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule